// File: doc/BRIEF.md
# Edge-Strobed Watchdog Timer

This block supervises a processor that must prove it is alive by pulling a strobe line from high to low at least once per timeout period. A free-running count of millisecond ticks restarts on every such falling edge. If a full period passes without one, the block sends a one-cycle timeout request to the reset sequencer, reloads itself and starts the next period. There is no way to switch it off.

Three periods can be chosen through a 2-bit select that carries the decoded state of a three-level board strap. The strobe edge is caught by an asynchronous flag, so a pulse much shorter than a clock period still counts. While the system is held in reset, the count stays at zero. Counting starts again from zero when that reset releases.

Top module: `wdog_strobe_timer`

## Requirements
- R1: While rst_ni is low, timeout_o is low and the tick count is cleared.
- R2: The select period_sel_i chooses the period in ms ticks: code 00 gives 150, 01 gives 610, 10 gives 1200, and the spare code 11 also gives 1200. Each default lies inside its allowed window of 62.5–250, 250–1000 and 500–2000 ms. timeout_o is high in the cycle after the clock edge that samples the N-th tick since the last restart.
- R3: A high-to-low edge on strobe_i restarts the count from zero within four clock cycles. This holds even for a pulse shorter than one clock period.
- R4: A low-to-high edge on strobe_i, or a strobe held at a steady level, does not restart the count.
- R5: No input disables the block: with the strobe left static, timeouts keep recurring once per period.
- R6: timeout_o is high for exactly one clock cycle. The count reloads on the same edge, so the next timeout comes exactly one period later.
- R7: While sys_rst_i is high, the count is held at zero and no timeout is raised. After release, counting starts from zero.
- R8: If period_sel_i is changed to a period shorter than the count already elapsed, the next tick raises the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Service strobe; a falling edge restarts the period |
| period_sel_i | input | 2 | Decoded three-level period strap |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| sys_rst_i | input | 1 | System reset state; high holds the count at zero |
| timeout_o | output | 1 | One-cycle timeout request to the reset sequencer |

## Verification
The assertions check several properties on every cycle. The timeout pulse lasts one cycle and comes only from a sampled tick. The count is zero after a timeout, after a restart and under system reset. The count never passes the longest period. A synchronized restart is never wider than one cycle. Only the bench scenarios can show the period lengths for each select code, because they count ticks. The same holds for three other behaviours: a sub-cycle strobe pulse is caught, a rising edge or a steady level is ignored, and a period switch after the new limit has already passed expires on the next tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_SPARE = 2'b11
  } wd_sel_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wdog_edge_catch.sv
// Sets on a strobe falling edge independent of clk; cleared by ack from clk domain.
module wdog_edge_catch (
  input  logic strobe_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic flag_o
);
  always_ff @(negedge strobe_i or negedge rst_ni or posedge ack_i) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (ack_i)  flag_o <= 1'b0;
    else             flag_o <= 1'b1;
  end
endmodule

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_period_dec.sv
module wdog_period_dec
  import wdog_pkg::*;
#(
  parameter int unsigned SHORT_MS = 150,
  parameter int unsigned MID_MS   = 610,
  parameter int unsigned LONG_MS  = 1200,
  parameter int unsigned CNT_W    = 11
) (
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] limit_o
);
  always_comb begin
    unique case (wd_sel_e'(sel_i))
      SEL_SHORT: limit_o = CNT_W'(SHORT_MS);
      SEL_MID:   limit_o = CNT_W'(MID_MS);
      SEL_LONG:  limit_o = CNT_W'(LONG_MS);
      default:   limit_o = CNT_W'(LONG_MS); // spare code folds to long
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W   = 11,
  parameter int unsigned MAX_LIM = 1200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_rst_i,
  input  logic             kick_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire;

  // >= so a shrunk period past its limit still expires
  assign expire = tick_i && (cnt_q >= limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (sys_rst_i || kick_i) begin
        cnt_q <= '0;
      end else if (expire) begin
        cnt_q     <= '0;
        timeout_o <= 1'b1;
      end else if (tick_i) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> cnt_q == '0);
  a_r7_sysrst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> (cnt_q == '0) && !timeout_o);
  a_r3_kick_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0) && !timeout_o);
  a_r2_tick_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(tick_i));
  a_r8_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_LIM));
endmodule

// File: rtl/wdog_strobe_timer.sv
module wdog_strobe_timer
  import wdog_pkg::*;
#(
  parameter int unsigned SHORT_MS    = 150,
  parameter int unsigned MID_MS      = 610,
  parameter int unsigned LONG_MS     = 1200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] period_sel_i,
  input  logic       ms_tick_i,
  input  logic       sys_rst_i,
  output logic       timeout_o
);
  localparam int unsigned MAX_LIM = max3(SHORT_MS, MID_MS, LONG_MS);
  localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

  logic             flag;
  logic             seen;
  logic             ack_q;
  logic             kick;
  logic [CNT_W-1:0] limit;

  wdog_edge_catch u_catch (
    .strobe_i (strobe_i),
    .rst_ni   (rst_ni),
    .ack_i    (ack_q),
    .flag_o   (flag)
  );

  wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (flag),
    .q_o    (seen)
  );

  // ack holds the catch flag clear until the synchronized copy drops
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= seen;

  assign kick = seen && !ack_q;

  wdog_period_dec #(
    .SHORT_MS (SHORT_MS),
    .MID_MS   (MID_MS),
    .LONG_MS  (LONG_MS),
    .CNT_W    (CNT_W)
  ) u_dec (
    .sel_i   (period_sel_i),
    .limit_o (limit)
  );

  wdog_counter #(
    .CNT_W   (CNT_W),
    .MAX_LIM (MAX_LIM)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_rst_i (sys_rst_i),
    .kick_i    (kick),
    .tick_i    (ms_tick_i),
    .limit_i   (limit),
    .timeout_o (timeout_o)
  );

  a_r3_kick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick |=> !kick);
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seen) |-> !ack_q);
endmodule

// File: tb/tb_wdog_strobe_timer.sv
`timescale 1ns/1ps
module tb_wdog_strobe_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       tick = 1'b0;
  logic       sys_rst = 1'b0;
  logic       timeout;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wdog_strobe_timer dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .strobe_i     (strobe),
    .period_sel_i (sel),
    .ms_tick_i    (tick),
    .sys_rst_i    (sys_rst),
    .timeout_o    (timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_ticks(input int n, output int hits, output int first);
    hits = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      if (timeout) begin
        hits++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic sys_reset();
    @(negedge clk) sys_rst = 1'b1;
    repeat (2) @(negedge clk);
    sys_rst = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check("R1 timeout low in reset", timeout, 0);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_period(input logic [1:0] code, input int n, input string req);
    int hits, first;
    sel = code;
    sys_reset();
    run_ticks(n, hits, first);
    check({req, " first timeout tick"}, first, n);
    check({req, " single timeout"}, hits, 1);
  endtask

  task automatic t_short_strobe();
    int hits, first;
    sel = 2'b00;
    sys_reset();
    run_ticks(100, hits, first);
    check("R3 no timeout before strobe", hits, 0);
    @(negedge clk); #2 strobe = 1'b0; #3 strobe = 1'b1; // 3 ns pulse
    settle();
    run_ticks(150, hits, first);
    check("R3 restart by short pulse", first, 150);
  endtask

  task automatic t_rising_ignored();
    int hits, first;
    sel = 2'b00;
    @(negedge clk) strobe = 1'b0;
    settle();
    sys_reset();
    run_ticks(100, hits, first);
    check("R4 low level no restart", hits, 0);
    @(negedge clk) strobe = 1'b1;
    settle();
    run_ticks(50, hits, first);
    check("R4 rising edge no restart", first, 50);
  endtask

  task automatic t_no_disable();
    int hits, first;
    sel = 2'b00;
    sys_reset();
    run_ticks(450, hits, first);
    check("R5 recurring timeouts", hits, 3);
  endtask

  task automatic t_pulse_width();
    int hits, first;
    sel = 2'b00;
    sys_reset();
    run_ticks(149, hits, first);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R6 timeout high", timeout, 1);
    @(negedge clk);
    check("R6 timeout one cycle", timeout, 0);
  endtask

  task automatic t_sys_hold();
    int hits, first;
    sel = 2'b00;
    @(negedge clk) sys_rst = 1'b1;
    run_ticks(400, hits, first);
    check("R7 no timeout in system reset", hits, 0);
    @(negedge clk) sys_rst = 1'b0;
    run_ticks(150, hits, first);
    check("R7 count from zero after release", first, 150);
  endtask

  task automatic t_shrink();
    int hits, first;
    sel = 2'b10;
    sys_reset();
    run_ticks(300, hits, first);
    check("R8 no timeout on long period", hits, 0);
    sel = 2'b00;
    run_ticks(1, hits, first);
    check("R8 expiry on next tick", first, 1);
  endtask

  initial begin
    t_reset_state();
    t_period(2'b00, 150,  "R2 code00");
    t_period(2'b01, 610,  "R2 code01");
    t_period(2'b10, 1200, "R2 code10");
    t_period(2'b11, 1200, "R2 code11");
    t_short_strobe();
    t_rising_ignored();
    t_no_disable();
    t_pulse_width();
    t_sys_hold();
    t_shrink();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule